// File: doc/BRIEF.md
# Result Readout Byte Streamer

This block turns stored converter results into the byte stream that a two-wire slave engine shifts out during a read. The slave engine asks for a byte with a one-cycle request strobe. One clock later the block presents the byte. It then waits for the master's acknowledge bit for that byte. Each result is sent as two bytes. The high byte carries ones in its upper bits above the most significant result bits. The low byte carries the remaining result bits. Results leave in stored order, from address 0 upward. After the last stored result the address goes back to the first one, so a master that keeps acknowledging keeps getting valid data.

A not-acknowledge ends the stream and raises the idle flag that the power-down logic uses. The read position is kept after a not-acknowledge, so a later request picks up from the byte that was refused. A STOP or a repeated START also returns the block to idle, and it releases the stored position as well: the next read starts again at the first result. Memory reads are asynchronous. The block drives the read address from a register and samples the data when a request arrives.

Top module: `result_byte_streamer`

## Requirements
- R1: After reset, idle is 1, tx_valid is 0, tx_byte is 0 and mem_addr is 0.
- R2: A byte_req while no byte is outstanding raises tx_valid for exactly one cycle, one clock later, and drops idle at that same edge.
- R3: A high byte (the first of a pair) is {6'b111111, result[9:8]}.
- R4: A low byte (the second of a pair) is result[7:0] of the same address as its high byte.
- R5: An acknowledge (ack_valid=1, ack_nack=0) of an outstanding high byte moves to the low byte of the same address. An acknowledge of a low byte moves to the high byte of the next address.
- R6: When the acknowledged low byte belongs to address result_count-1 or above, or when result_count is 0, the next address is 0.
- R7: A not-acknowledge (ack_valid=1, ack_nack=1) of an outstanding byte sets idle and keeps the read position. The next byte_req resends that same byte.
- R8: stop_seen or rstart_seen sets idle, clears the position to the high byte of address 0, and cancels any outstanding byte. It takes priority over byte_req and ack_valid in the same cycle.
- R9: ack_valid with no byte outstanding is ignored: mem_addr and the next byte sent are unchanged.
- R10: A byte_req while a byte is still awaiting its acknowledge is ignored: tx_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_req | input | 1 | Slave engine asks for the next byte |
| ack_valid | input | 1 | Master's acknowledge bit for the last byte is present |
| ack_nack | input | 1 | 1 = not-acknowledge, 0 = acknowledge |
| stop_seen | input | 1 | STOP condition detected |
| rstart_seen | input | 1 | Repeated START detected |
| result_count | input | ADDR_W+1 | Number of stored results |
| mem_rdata | input | RES_W | Result at mem_addr (asynchronous read) |
| mem_addr | output | ADDR_W | Result memory read address |
| tx_byte | output | 8 | Byte to shift out |
| tx_valid | output | 1 | tx_byte was loaded this cycle |
| idle | output | 1 | No read in progress; power-down allowed |

## Verification
A wrong half-select bit shows up on the very next tx_valid: it produces a byte without its run of six ones, or a padded byte where raw low bits were expected. A wrong address or wrap shows up one request later, because the data returned does not match the expected memory entry. A lost pending flag shows up at once as an extra tx_valid or as a stall. A position that is not cleared shows up on the first byte after a STOP or repeated START. The random stream mixes acknowledges, refusals, stray acknowledges and bus conditions, so each of these faults is exposed within a few requests.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        HALF_HI = 1'b0,
        HALF_LO = 1'b1
    } half_e;
endpackage

// File: rtl/rbs_framer.sv
module rbs_framer #(
    parameter int RES_W = 10
) (
    input  logic [RES_W-1:0]    res_i,
    input  rbs_pkg::half_e      half_i,
    output rbs_pkg::byte_t      byte_o
);
    localparam int BW    = rbs_pkg::BYTE_W;
    localparam int HI_W  = RES_W - BW;
    localparam int PAD_W = 2*BW - RES_W;

    rbs_pkg::byte_t hi_byte;

    generate
        if (PAD_W > 0) begin : g_pad
            assign hi_byte = {{PAD_W{1'b1}}, res_i[RES_W-1:BW]};
        end else begin : g_nopad
            assign hi_byte = res_i[RES_W-1:BW];
        end
    endgenerate

    always_comb begin
        if (half_i == rbs_pkg::HALF_HI) begin
            byte_o = hi_byte;
        end else begin
            byte_o = res_i[BW-1:0];
        end
    end

    if (HI_W < 1 || HI_W > BW) begin : g_bad_width
        initial begin
            $display("rbs_framer: RES_W must lie in 9..16");
        end
    end
endmodule

// File: rtl/rbs_wrap.sv
module rbs_wrap #(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W:0]   count_i,
    output logic [ADDR_W-1:0] next_o
);
    logic [ADDR_W:0] incr;

    always_comb begin
        incr = {1'b0, addr_i} + {{ADDR_W{1'b0}}, 1'b1};
        if (count_i == '0 || incr >= count_i) begin
            next_o = '0;
        end else begin
            next_o = incr[ADDR_W-1:0];
        end
    end
endmodule

// File: rtl/result_byte_streamer.sv
module result_byte_streamer #(
    parameter int ADDR_W = 4,
    parameter int RES_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_req,
    input  logic              ack_valid,
    input  logic              ack_nack,
    input  logic              stop_seen,
    input  logic              rstart_seen,
    input  logic [ADDR_W:0]   result_count,
    input  logic [RES_W-1:0]  mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        tx_byte,
    output logic              tx_valid,
    output logic              idle
);
    typedef struct packed {
        logic               active;
        logic               pending;
        rbs_pkg::half_e     half;
        logic [ADDR_W-1:0]  addr;
        logic               tx_valid;
        rbs_pkg::byte_t     tx_byte;
    } state_t;

    state_t state_d, state_q;

    rbs_pkg::byte_t    framed;
    logic [ADDR_W-1:0] addr_next;
    logic              bus_release;

    rbs_framer #(.RES_W(RES_W)) u_framer (
        .res_i  (mem_rdata),
        .half_i (state_q.half),
        .byte_o (framed)
    );

    rbs_wrap #(.ADDR_W(ADDR_W)) u_wrap (
        .addr_i  (state_q.addr),
        .count_i (result_count),
        .next_o  (addr_next)
    );

    assign bus_release = stop_seen | rstart_seen;

    always_comb begin
        state_d          = state_q;
        state_d.tx_valid = 1'b0;
        if (bus_release) begin
            state_d.active  = 1'b0;
            state_d.pending = 1'b0;
            state_d.half    = rbs_pkg::HALF_HI;
            state_d.addr    = '0;
        end else if (state_q.pending) begin
            if (ack_valid) begin
                state_d.pending = 1'b0;
                if (ack_nack) begin
                    state_d.active = 1'b0;
                end else if (state_q.half == rbs_pkg::HALF_LO) begin
                    state_d.half = rbs_pkg::HALF_HI;
                    state_d.addr = addr_next;
                end else begin
                    state_d.half = rbs_pkg::HALF_LO;
                end
            end
        end else if (byte_req) begin
            state_d.tx_valid = 1'b1;
            state_d.tx_byte  = framed;
            state_d.active   = 1'b1;
            state_d.pending  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{
                active:   1'b0,
                pending:  1'b0,
                half:     rbs_pkg::HALF_HI,
                addr:     '0,
                tx_valid: 1'b0,
                tx_byte:  '0
            };
        end else begin
            state_q <= state_d;
        end
    end

    assign mem_addr = state_q.addr;
    assign tx_byte  = state_q.tx_byte;
    assign tx_valid = state_q.tx_valid;
    assign idle     = ~state_q.active;
endmodule

// File: rtl/rbs_checker.sv
module rbs_checker #(
    parameter int ADDR_W = 4,
    parameter int RES_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_req,
    input logic              ack_valid,
    input logic              ack_nack,
    input logic              stop_seen,
    input logic              rstart_seen,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        tx_byte,
    input logic              tx_valid,
    input logic              idle,
    input logic              pending,
    input logic              half
);
    localparam int HI_W = RES_W - 8;

    logic rel;
    assign rel = stop_seen | rstart_seen;

    assert_valid_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> ($past(byte_req) && !idle));

    assert_pad_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && $past(half) == 1'b0) |-> (&tx_byte[7:HI_W]));

    assert_nack_idles_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_nack && pending && !rel) |=> (idle && $stable(mem_addr)));

    assert_release_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rel |=> (idle && mem_addr == '0 && !tx_valid && !pending));

    assert_stray_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !pending && !rel) |=> $stable(mem_addr));

    assert_busy_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_req && pending && !rel) |=> !tx_valid);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |-> (idle && !tx_valid && mem_addr == '0));
endmodule

bind result_byte_streamer rbs_checker #(.ADDR_W(ADDR_W), .RES_W(RES_W)) u_rbs_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_req    (byte_req),
    .ack_valid   (ack_valid),
    .ack_nack    (ack_nack),
    .stop_seen   (stop_seen),
    .rstart_seen (rstart_seen),
    .mem_addr    (mem_addr),
    .tx_byte     (tx_byte),
    .tx_valid    (tx_valid),
    .idle        (idle),
    .pending     (state_q.pending),
    .half        (state_q.half)
);

// File: tb/result_byte_streamer_test.sv
`timescale 1ns/1ps
module result_byte_streamer_test;
    localparam int AW = 4;
    localparam int RW = 10;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          byte_req = 1'b0, ack_valid = 1'b0, ack_nack = 1'b0;
    logic          stop_seen = 1'b0, rstart_seen = 1'b0;
    logic [AW:0]   result_count = '0;
    logic [RW-1:0] mem_rdata;
    logic [AW-1:0] mem_addr;
    logic [7:0]    tx_byte;
    logic          tx_valid, idle;

    logic [RW-1:0] mem [DEPTH];

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model of the read position
    bit          m_active = 0, m_pend = 0, m_half = 0;
    int          m_addr = 0;
    logic [7:0]  m_last = 8'h00;

    always #2.5 clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    result_byte_streamer #(.ADDR_W(AW), .RES_W(RW)) uut (
        .clk, .rst_n, .byte_req, .ack_valid, .ack_nack, .stop_seen, .rstart_seen,
        .result_count, .mem_rdata, .mem_addr, .tx_byte, .tx_valid, .idle
    );

    function automatic logic [7:0] frame(logic [RW-1:0] r, bit lo);
        return lo ? r[7:0] : {6'b111111, r[9:8]};
    endfunction

    function automatic int next_addr(int a, int cnt);
        if (cnt == 0 || a + 1 >= cnt) return 0;
        return a + 1;
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(bit rq, bit av, bit nk, bit sp, bit rs);
        bit       exp_v = 0;
        bit       was_pend = m_pend;
        bit       was_lo = m_half;
        bit       is_busy_req = rq && m_pend;
        logic [7:0] exp_b = m_last;
        @(negedge clk);
        byte_req = rq; ack_valid = av; ack_nack = nk; stop_seen = sp; rstart_seen = rs;
        if (sp || rs) begin
            m_active = 0; m_pend = 0; m_half = 0; m_addr = 0;
        end else if (m_pend) begin
            if (av) begin
                m_pend = 0;
                if (nk) m_active = 0;
                else if (m_half) begin m_half = 0; m_addr = next_addr(m_addr, int'(result_count)); end
                else m_half = 1;
            end
        end else if (rq) begin
            exp_v = 1; exp_b = frame(mem[m_addr], m_half); m_last = exp_b;
            m_active = 1; m_pend = 1;
        end
        @(posedge clk);
        #1;
        byte_req = 0; ack_valid = 0; ack_nack = 0; stop_seen = 0; rstart_seen = 0;
        if (is_busy_req && !sp && !rs) chk("R10 busy request tx_valid", tx_valid, 0);
        else chk("R2 tx_valid", tx_valid, exp_v);
        if (exp_v) begin
            if (was_lo) chk("R4 low byte", tx_byte, exp_b);
            else chk("R3 high byte", tx_byte, exp_b);
        end
        if (sp || rs) chk("R8 release address", mem_addr, 0);
        else if (av && !was_pend) chk("R9 stray ack address", mem_addr, m_addr);
        else chk("R5 R6 address", mem_addr, m_addr);
        if (av && nk && was_pend && !sp && !rs) chk("R7 nack idle", idle, 1);
        else chk("R8 idle", idle, !m_active);
    endtask

    task automatic send_ack(bit nk);
        step(1, 0, 0, 0, 0);
        step(0, 1, nk, 0, 0);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) mem[i] = RW'($urandom);
        result_count = 3;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset idle", idle, 1);
        chk("R1 reset tx_valid", tx_valid, 0);
        chk("R1 reset tx_byte", tx_byte, 0);
        chk("R1 reset mem_addr", mem_addr, 0);
        @(negedge clk);
        rst_n = 1;

        // full pass across three results and a wrap (R5, R6)
        for (int i = 0; i < 8; i++) send_ack(0);
        // refusal keeps position, resend same byte (R7)
        send_ack(1);
        send_ack(0);
        // stray ack ignored (R9)
        step(0, 1, 0, 0, 0);
        step(0, 1, 1, 0, 0);
        send_ack(0);
        // busy request ignored (R10)
        step(1, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0);
        // release mid-pair, same-cycle request loses (R8)
        step(1, 0, 0, 0, 0);
        step(1, 1, 0, 1, 0);
        send_ack(0);
        step(0, 0, 0, 0, 1);
        // count zero and one pin the address at 0 (R6)
        result_count = 0;
        for (int i = 0; i < 4; i++) send_ack(0);
        result_count = 1;
        for (int i = 0; i < 4; i++) send_ack(0);
        step(0, 0, 0, 1, 0);

        // constrained random traffic
        for (int n = 0; n < 6000; n++) begin
            int r = int'($urandom_range(0, 99));
            if (n % 500 == 0) begin
                result_count = (AW+1)'($urandom_range(0, DEPTH));
                step(0, 0, 0, 1, 0);
            end
            if (r < 3) step(0, 0, 0, 1, 0);
            else if (r < 5) step(bit'($urandom), bit'($urandom), 0, 0, 1);
            else if (r < 10) step(1, 1, bit'($urandom), 0, 0);
            else if (m_pend) step(bit'(r < 15), bit'(r < 80), bit'(r < 22), 0, 0);
            else step(bit'(r < 85), bit'(r > 95), 0, 0, 0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule